// File: doc/BRIEF.md
# DDR2 Auto-Refresh Scheduler

This block decides when a DDR2 memory controller issues auto-refresh commands. An interval timer runs off a programmable refresh period. Each time the period runs out, one more refresh becomes owed. The controller may let owed refreshes pile up while it is busy with traffic, up to a depth of eight. At that depth the block raises an urgency flag, and the controller must then close every bank and allow a refresh before the next period ends. Because at most eight refreshes can be deferred, two refresh commands are never more than nine periods apart.

A refresh goes onto the command pins only when four things hold: the controller grants the slot, at least one refresh is owed, every bank has reported idle for the programmed precharge time, and the refresh cycle time since the previous refresh has run out. The refresh is driven for exactly one cycle. At all other times the command pins carry a no-operation with chip select high. From the refresh cycle until the refresh cycle time has elapsed, an activate-inhibit output is held high so that the controller's bank logic does not open a row. The address bus plays no part in a refresh and is not driven here. The three timing values are inputs counted in clock cycles. The refresh period is sampled while reset is held.

Top module: `ddr2_refresh_sched`

## Requirements
- R1: The command pins {cs_n, ras_n, cas_n, we_n} only ever read 4'b0001 (refresh) or 4'b1111 (no-operation). A refresh lasts one cycle per issue.
- R2: Number the first clock edge with rst_n high as edge 1. pend_cnt rises by one at edges trefi_cyc, 2·trefi_cyc, and so on. It falls by one at the edge that drives a refresh. When both happen at the same edge, it is unchanged.
- R3: A refresh is driven in a cycle only if banks_idle was high in each of the trp_cyc cycles just before that cycle.
- R4: Two refresh cycles are at least trfc_cyc cycles apart (trfc_cyc ≥ 1).
- R5: act_block is high in a refresh cycle and in the trfc_cyc−1 cycles after it. It is low at all other times.
- R6: No refresh is driven while pend_cnt is zero.
- R7: pend_cnt saturates at 8. An expiry at 8 with no refresh leaves it at 8. ref_urgent is high exactly while pend_cnt equals 8.
- R8: When ref_grant is high in a cycle, and the conditions of R3, R4 and R6 would all be met for the next cycle, the refresh is driven in the next cycle.
- R9: While rst_n is low, the pins read no-operation, pend_cnt is 0, and ref_urgent and act_block are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trefi_cyc | input | CNT_W | Refresh period in cycles (≥ 1), sampled in reset |
| trp_cyc | input | CNT_W | Required all-idle time before a refresh |
| trfc_cyc | input | CNT_W | Refresh cycle time (≥ 1) |
| banks_idle | input | 1 | All banks precharged and idle |
| ref_grant | input | 1 | Controller permits a refresh in the next cycle |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| pend_cnt | output | 4 | Refreshes owed |
| ref_urgent | output | 1 | Deferral limit reached |
| act_block | output | 1 | Activate not allowed |

## Verification
The bench sweeps 27 combinations of refresh period, precharge time and cycle time. It first withholds the grant until the owed count has saturated. It then grants with a pseudo-random pattern while banks_idle drops out briefly. The corner cases are:
- An expiry that lands on the same edge as a refresh. A design that mishandles it drifts the owed count.
- An expiry at the ceiling. A design that wraps it drops urgency and loses eight refreshes.
- A grant given one cycle before the idle window or the refresh cycle time is complete. An off-by-one design would either issue early, breaking the precharge or cycle-time rule, or issue one cycle late, which the exact-cycle comparison against the bench's own prediction catches.
- A one-cycle refresh cycle time, where back-to-back refreshes are legal.

// File: rtl/ddr2_ref_pkg.sv
// Shared types for the refresh scheduler: the command-pin bundle and
// the two encodings this block ever drives.
package ddr2_ref_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } ddr_cmd_t;

    localparam ddr_cmd_t CMD_NOP = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam ddr_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/refi_timer.sv
// Refresh interval timer. Emits a one-cycle tick every trefi_cyc edges
// after reset release. Assumes trefi_cyc >= 1 and that it is stable
// while rst_n is low (it is loaded there).
module refi_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] trefi_cyc,
    output logic             tick
);
    logic [CNT_W-1:0] remain_q;

    assign tick = (remain_q == '0);

    // Count down once per cycle and reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= trefi_cyc - CNT_W'(1);
        end else if (tick) begin
            remain_q <= trefi_cyc - CNT_W'(1);
        end else begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/ref_post_counter.sv
// Count of refreshes owed. It rises on each interval tick and falls on
// each issued refresh, and saturates at MAX_POST. Assumes dec is only
// raised while the count is non-zero.
module ref_post_counter #(
    parameter int MAX_POST = 8,
    localparam int PEND_W = $clog2(MAX_POST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    output logic [PEND_W-1:0] pend,
    output logic              full
);
    localparam logic [PEND_W-1:0] FULL_VAL = PEND_W'(MAX_POST);

    assign full = (pend == FULL_VAL);

    // Net update: tick and refresh together leave the count unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   if (!full) pend <= pend + PEND_W'(1);
                2'b01:   if (pend != '0) pend <= pend - PEND_W'(1);
                default: pend <= pend;
            endcase
        end
    end
endmodule

// File: rtl/rfc_window.sv
// Refresh cycle window. Loaded with trfc_cyc when a refresh is driven.
// busy covers the refresh cycle and the trfc_cyc-1 cycles after it.
// ready allows a decision that places the next refresh exactly
// trfc_cyc cycles after the last one. Assumes trfc_cyc >= 1.
module rfc_window #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] trfc_cyc,
    output logic             busy,
    output logic             ready
);
    logic [CNT_W-1:0] left_q;

    assign busy  = (left_q != '0);
    assign ready = (left_q <= CNT_W'(1));

    // Load on refresh, otherwise run down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= trfc_cyc;
        end else if (busy) begin
            left_q <= left_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/idle_tracker.sv
// Measures how long the banks have been idle without a break. met is
// high when a refresh registered at the coming edge would follow
// trp_cyc consecutive idle cycles (this one included).
module idle_tracker #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             banks_idle,
    input  logic [CNT_W-1:0] trp_cyc,
    output logic             met
);
    logic [CNT_W-1:0] run_q;
    logic [CNT_W:0]   run_incl;

    assign run_incl = {1'b0, run_q} + (CNT_W+1)'(1);
    assign met      = banks_idle && (run_incl >= {1'b0, trp_cyc});

    // Saturating run length of idle cycles; cleared by any busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!banks_idle) begin
            run_q <= '0;
        end else if (run_q != '1) begin
            run_q <= run_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ddr2_refresh_sched.sv
// Auto-refresh scheduler top. Combines the interval timer, owed-refresh
// counter, idle tracker and refresh cycle window. It drives a registered
// refresh or no-operation onto the command pins. Assumes the controller
// drives no command of its own in a cycle where cs_n is low here.
module ddr2_refresh_sched #(
    parameter int CNT_W    = 16,
    parameter int MAX_POST = 8,
    localparam int PEND_W  = $clog2(MAX_POST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  trefi_cyc,
    input  logic [CNT_W-1:0]  trp_cyc,
    input  logic [CNT_W-1:0]  trfc_cyc,
    input  logic              banks_idle,
    input  logic              ref_grant,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [PEND_W-1:0] pend_cnt,
    output logic              ref_urgent,
    output logic              act_block
);
    import ddr2_ref_pkg::*;

    logic     tick;
    logic     idle_met;
    logic     rfc_ready;
    logic     fire;
    ddr_cmd_t cmd_q;

    refi_timer #(.CNT_W(CNT_W)) u_refi (
        .clk       (clk),
        .rst_n     (rst_n),
        .trefi_cyc (trefi_cyc),
        .tick      (tick)
    );

    ref_post_counter #(.MAX_POST(MAX_POST)) u_post (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick),
        .dec   (fire),
        .pend  (pend_cnt),
        .full  (ref_urgent)
    );

    idle_tracker #(.CNT_W(CNT_W)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .banks_idle (banks_idle),
        .trp_cyc    (trp_cyc),
        .met        (idle_met)
    );

    rfc_window #(.CNT_W(CNT_W)) u_rfc (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (fire),
        .trfc_cyc (trfc_cyc),
        .busy     (act_block),
        .ready    (rfc_ready)
    );

    // Issue decision for the next cycle: every timing and credit condition.
    assign fire = ref_grant && idle_met && rfc_ready && (pend_cnt != '0);

    // Command pin register: a one-cycle refresh, otherwise no-operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_NOP;
        end else begin
            cmd_q <= fire ? CMD_REF : CMD_NOP;
        end
    end

    assign cs_n  = cmd_q.cs_n;
    assign ras_n = cmd_q.ras_n;
    assign cas_n = cmd_q.cas_n;
    assign we_n  = cmd_q.we_n;
endmodule

// File: rtl/ddr2_refresh_sched_chk.sv
// Protocol checker for the refresh scheduler. It observes the top-level
// ports only and keeps its own count of cycles since the last refresh.
module ddr2_refresh_sched_chk #(
    parameter int CNT_W    = 16,
    parameter int MAX_POST = 8,
    localparam int PEND_W  = $clog2(MAX_POST + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  trfc_cyc,
    input logic              banks_idle,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [PEND_W-1:0] pend_cnt,
    input logic              ref_urgent,
    input logic              act_block
);
    logic           is_ref;
    logic [CNT_W:0] since_q;
    logic           seen_q;

    assign is_ref = !cs_n;

    // Cycles since the most recent refresh, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (is_ref) begin
            since_q <= (CNT_W+1)'(1);
            seen_q  <= 1'b1;
        end else if (since_q != '1) begin
            since_q <= since_q + (CNT_W+1)'(1);
        end
    end

    assert_cmd_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n ? (ras_n && cas_n && we_n) : (!ras_n && !cas_n && we_n));

    assert_idle_before_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> $past(banks_idle));

    assert_rfc_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && seen_q) |-> (since_q >= {1'b0, trfc_cyc}));

    assert_block_on_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> act_block);

    assert_no_empty_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> ($past(pend_cnt) != '0));

    assert_pend_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= PEND_W'(MAX_POST));

    assert_urgent_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_urgent) |-> ($past(pend_cnt) == PEND_W'(MAX_POST - 1)));
endmodule

bind ddr2_refresh_sched ddr2_refresh_sched_chk #(
    .CNT_W    (CNT_W),
    .MAX_POST (MAX_POST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trfc_cyc   (trfc_cyc),
    .banks_idle (banks_idle),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .pend_cnt   (pend_cnt),
    .ref_urgent (ref_urgent),
    .act_block  (act_block)
);

// File: tb/tb_ddr2_refresh_sched.sv
// Sweep bench: for each timing configuration, starve the grant until the
// owed count saturates, then grant pseudo-randomly. Every cycle is
// compared against a prediction derived from the requirements.
module tb_ddr2_refresh_sched;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [CW-1:0] trefi_cyc, trp_cyc, trfc_cyc;
    logic          banks_idle, ref_grant;
    logic          cs_n, ras_n, cas_n, we_n;
    logic [3:0]    pend_cnt;
    logic          ref_urgent, act_block;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;

    ddr2_refresh_sched #(.CNT_W(CW), .MAX_POST(8)) dut (
        .clk(clk), .rst_n(rst_n), .trefi_cyc(trefi_cyc), .trp_cyc(trp_cyc),
        .trfc_cyc(trfc_cyc), .banks_idle(banks_idle), .ref_grant(ref_grant),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .pend_cnt(pend_cnt), .ref_urgent(ref_urgent), .act_block(act_block)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_cfg(input int tr, input int tp, input int tf);
        int        m_pend, m_idle, m_since, ncyc;
        bit        gp, ip, efire, afire, c_idle, c_gap, c_pend, tick;
        logic [15:0] lfsr;
        string     tag;
        lfsr = 16'hACE1 ^ 16'(tr * 31 + tp * 7 + tf);
        @(negedge clk);
        rst_n = 1'b0; trefi_cyc = CW'(tr); trp_cyc = CW'(tp); trfc_cyc = CW'(tf);
        ref_grant = 1'b1; banks_idle = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R9", "reset pins", int'({cs_n, ras_n, cas_n, we_n}), 15);
        chk(pend_cnt == 0, "R9", "reset pend", int'(pend_cnt), 0);
        chk(!ref_urgent && !act_block, "R9", "reset urgent/block", int'({ref_urgent, act_block}), 0);
        rst_n = 1'b1; ref_grant = 1'b0; banks_idle = 1'b1;
        gp = 1'b0; ip = 1'b1;
        m_pend = 0; m_idle = 0; m_since = 1000;
        ncyc = 16 * tr + 60;
        for (int j = 1; j <= ncyc; j++) begin
            @(negedge clk);
            // Prediction for edge j from inputs held in the cycle before it.
            c_idle = ip && (m_idle + 1 >= tp);
            c_gap  = (m_since + 1 >= tf);
            c_pend = (m_pend > 0);
            efire  = gp && c_idle && c_gap && c_pend;
            tick   = (j % tr) == 0;
            m_pend = m_pend - int'(efire) + int'(tick);
            if (m_pend > 8) m_pend = 8;
            m_idle  = ip ? m_idle + 1 : 0;
            m_since = efire ? 0 : ((m_since < 1000) ? m_since + 1 : 1000);

            afire = !cs_n;
            // R1: only the two legal encodings
            chk(({cs_n, ras_n, cas_n, we_n} == 4'b0001) || ({cs_n, ras_n, cas_n, we_n} == 4'b1111),
                "R1", "pin encoding", int'({cs_n, ras_n, cas_n, we_n}), afire ? 1 : 15);
            if (afire && !c_pend)      tag = "R6";
            else if (afire && !c_idle) tag = "R3";
            else if (afire && !c_gap)  tag = "R4";
            else                       tag = "R8";
            chk(afire == efire, tag, "refresh issue", int'(afire), int'(efire));
            chk(int'(pend_cnt) == m_pend, "R2", "pending count", int'(pend_cnt), m_pend);
            chk(ref_urgent == (m_pend == 8), "R7", "urgency", int'(ref_urgent), int'(m_pend == 8));
            chk(act_block == (m_since < tf), "R5", "activate block", int'(act_block), int'(m_since < tf));

            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ref_grant  = (j > 9 * tr + 1) ? (lfsr[0] | lfsr[1]) : 1'b0;
            banks_idle = (lfsr[4:2] != 3'b000);
            gp = ref_grant; ip = banks_idle;
        end
    endtask

    initial begin
        rst_n = 1'b0; trefi_cyc = '0; trp_cyc = '0; trfc_cyc = '0;
        banks_idle = 1'b0; ref_grant = 1'b0;
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                for (int c = 0; c < 3; c++) begin
                    run_cfg(4 + 4 * a, 1 << b, (c == 0) ? 1 : 3 * c);
                end
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule